// File: doc/BRIEF.md
# Timer Underflow Interrupt Entry Sequencer

This block pairs a free-running 16-bit down-counter, used as a cycle counter, with the hardware sequence that enters an interrupt handler when that counter wraps from zero to 0xFFFF. On such a wrap it checks three gating conditions: the interrupt-enable bit of the status byte, a nonzero vector word, and a clear mask bit. When all three hold, it saves a four-byte frame on the stack through a byte-wide write port. The frame holds the status byte and a 3-byte program counter. The block then hands back a new stack pointer, a status byte with interrupts disabled, and a program counter loaded from the vector. Last, it holds the processor in a fixed stall.

The surrounding core supplies the current status byte, stack pointer, program counter and mask word. It also supplies the vector word that its memory holds at 0x0002C. It drives one tick per processor clock. It loads the returned stack pointer, status byte and program counter in the cycle where the update strobe is high, and it holds its own execution while busy is high. Stack addresses are 20 bits wide and lie in the top 64 KiB, in the form {4'hF, SP}.

Top module: `tmr_irq_entry`

## Requirements
- R1: After reset the count equals the parameter RESET_COUNT, and busy, mem_we, upd_valid, stall_cnt, sp_out, psw_out and pc_out are all zero.
- R2: The count drops by one on every clock edge where tick is high, holds when tick is low, and wraps from 0x0000 to 0xFFFF.
- R3: An underflow is a clock edge with tick high while the count is zero. Entry is taken on that edge only when all of these hold: psw_in bit 7 (interrupt enable) is 1, vec_in is nonzero, mask_in bit 4 is 0, and busy is low.
- R4: When an underflow fails any gating condition, no stack write occurs, busy stays low, sp_out/psw_out/pc_out keep their values, and the count carries on from 0xFFFF.
- R5: In the first cycle after a taken underflow, mem_we is 1, mem_addr is {4'hF, SP−1} and mem_wdata is the captured status byte. SP arithmetic is modulo 2^16.
- R6: In the next three cycles the program counter is written least-significant byte first: PC[7:0] to {4'hF, SP−4}, PC[15:8] to {4'hF, SP−3}, and {4'h0, PC[19:16]} to {4'hF, SP−2}.
- R7: In the cycle after the last push, upd_valid pulses for one cycle. In that cycle sp_out is SP−4, psw_out is the captured status byte with bit 7 cleared, and pc_out is the vector word zero-extended to 20 bits.
- R8: stall_cnt is 9 in the update cycle and falls by one per cycle down to 1, then returns to 0. busy is high for exactly 13 cycles, from the cycle after the taken underflow through the last stall cycle.
- R9: The counter keeps counting ticks while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one per processor clock |
| psw_in | input | 8 | Current status byte, bit 7 is interrupt enable |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 20 | Program counter to be saved |
| vec_in | input | 16 | Vector word held at address 0x0002C |
| mask_in | input | 16 | Mask word, bit 4 masks this source |
| count_out | output | 16 | Current counter value |
| mem_we | output | 1 | Stack byte write enable |
| mem_addr | output | 20 | Stack byte write address |
| mem_wdata | output | 8 | Stack byte write data |
| sp_out | output | 16 | Stack pointer after entry |
| psw_out | output | 8 | Status byte after entry |
| pc_out | output | 20 | Program counter after entry |
| upd_valid | output | 1 | One-cycle strobe to load sp_out, psw_out, pc_out |
| stall_cnt | output | 4 | Stall clocks remaining |
| busy | output | 1 | Entry sequence in progress |

## Verification
The hardest case to reach is a second underflow on a running counter, because after a wrap the next one lies 65536 ticks away. The bench gets there in its last test. It lets a first underflow be declined with the mask bit set, then clears the mask and ticks through the full period, and checks that the second wrap is taken with the right frame. A stack pointer of 0x0002 makes the frame addresses wrap across the 16-bit boundary. Each gating condition is failed on its own from one row of the vector table.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int SP_W   = 16;
  localparam int PC_W   = 20;
  localparam int ADDR_W = 20;
  localparam int FRAME_BYTES = 4;
  localparam int IDX_W  = $clog2(FRAME_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_STALL} seq_st_e;

  // distance below the old stack pointer for each frame slot
  function automatic logic [2:0] slot_back(input logic [IDX_W-1:0] idx);
    case (idx)
      2'd0:    return 3'd1;
      2'd1:    return 3'd4;
      2'd2:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stk_addr(input logic [SP_W-1:0] sp,
                                                 input logic [IDX_W-1:0] idx);
    logic [SP_W-1:0] a;
    a = sp - SP_W'(slot_back(idx));
    return {4'hF, a};
  endfunction

  function automatic logic [7:0] slot_byte(input logic [IDX_W-1:0] idx,
                                           input logic [7:0] psw,
                                           input logic [PC_W-1:0] pc);
    case (idx)
      2'd0:    return psw;
      2'd1:    return pc[7:0];
      2'd2:    return pc[15:8];
      default: return {4'h0, pc[19:16]};
    endcase
  endfunction
endpackage

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_COUNT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  assign wrap = tick && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= RESET_COUNT;
    else if (tick) count <= count - CNT_W'(1);
  end
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int IE_BIT   = 7,
  parameter int MASK_BIT = 4
) (
  input  logic [7:0]  psw,
  input  logic [15:0] vec,
  input  logic [15:0] mask,
  output logic        ok
);
  assign ok = psw[IE_BIT] && (vec != '0) && !mask[MASK_BIT];
endmodule

// File: rtl/tmr_entry_seq.sv
module tmr_entry_seq
  import tmr_irq_pkg::*;
#(
  parameter int IE_BIT     = 7,
  parameter int STALL_CLKS = 9,
  localparam int STALL_W   = $clog2(STALL_CLKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SP_W-1:0]   sp_in,
  input  logic [7:0]        psw_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [15:0]       vec_in,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [SP_W-1:0]   sp_out,
  output logic [7:0]        psw_out,
  output logic [PC_W-1:0]   pc_out,
  output logic              upd_valid,
  output logic [STALL_W-1:0] stall_cnt,
  output logic              busy
);
  seq_st_e          st;
  logic [IDX_W-1:0] idx;
  logic [SP_W-1:0]  sp_q;
  logic [7:0]       psw_q;
  logic [PC_W-1:0]  pc_q;
  logic [15:0]      vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; idx <= '0; stall_cnt <= '0; upd_valid <= 1'b0;
      sp_q <= '0; psw_q <= '0; pc_q <= '0; vec_q <= '0;
      sp_out <= '0; psw_out <= '0; pc_out <= '0;
    end else begin
      upd_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          sp_q <= sp_in; psw_q <= psw_in; pc_q <= pc_in; vec_q <= vec_in;
          idx <= '0;
          st  <= ST_PUSH;
        end
        ST_PUSH: if (idx == IDX_W'(FRAME_BYTES - 1)) begin
          st        <= ST_STALL;
          stall_cnt <= STALL_W'(STALL_CLKS);
          upd_valid <= 1'b1;
          sp_out    <= sp_q - SP_W'(FRAME_BYTES);
          psw_out   <= psw_q & ~(8'(1) << IE_BIT);
          pc_out    <= PC_W'(vec_q);
        end else begin
          idx <= idx + IDX_W'(1);
        end
        default: if (stall_cnt == STALL_W'(1)) begin
          st <= ST_IDLE; stall_cnt <= '0;
        end else begin
          stall_cnt <= stall_cnt - STALL_W'(1);
        end
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign mem_we    = (st == ST_PUSH);
  assign mem_addr  = mem_we ? stk_addr(sp_q, idx) : '0;
  assign mem_wdata = mem_we ? slot_byte(idx, psw_q, pc_q) : '0;
endmodule

// File: rtl/tmr_irq_entry.sv
module tmr_irq_entry #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] RESET_COUNT = '1,
  parameter int IE_BIT     = 7,
  parameter int MASK_BIT   = 4,
  parameter int STALL_CLKS = 9,
  localparam int STALL_W   = $clog2(STALL_CLKS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [7:0]         psw_in,
  input  logic [15:0]        sp_in,
  input  logic [19:0]        pc_in,
  input  logic [15:0]        vec_in,
  input  logic [15:0]        mask_in,
  output logic [CNT_W-1:0]   count_out,
  output logic               mem_we,
  output logic [19:0]        mem_addr,
  output logic [7:0]         mem_wdata,
  output logic [15:0]        sp_out,
  output logic [7:0]         psw_out,
  output logic [19:0]        pc_out,
  output logic               upd_valid,
  output logic [STALL_W-1:0] stall_cnt,
  output logic               busy
);
  logic ovf_evt;   // counter wraps on this edge
  logic gate_ok;   // all three gating conditions hold
  logic ovf_take;  // entry accepted on this edge

  tmr_down_cnt #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count_out), .wrap(ovf_evt));

  tmr_irq_gate #(.IE_BIT(IE_BIT), .MASK_BIT(MASK_BIT)) u_gate (
    .psw(psw_in), .vec(vec_in), .mask(mask_in), .ok(gate_ok));

  assign ovf_take = ovf_evt && gate_ok && !busy;

  tmr_entry_seq #(.IE_BIT(IE_BIT), .STALL_CLKS(STALL_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(ovf_take),
    .sp_in(sp_in), .psw_in(psw_in), .pc_in(pc_in), .vec_in(vec_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .psw_out(psw_out), .pc_out(pc_out),
    .upd_valid(upd_valid), .stall_cnt(stall_cnt), .busy(busy));
endmodule

// File: rtl/tmr_irq_entry_chk.sv
module tmr_irq_entry_chk #(
  parameter int CNT_W = 16,
  parameter int IE_BIT = 7,
  parameter int STALL_CLKS = 9,
  parameter int STALL_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [CNT_W-1:0]   count_out,
  input logic               mem_we,
  input logic [19:0]        mem_addr,
  input logic [7:0]         psw_out,
  input logic               upd_valid,
  input logic [STALL_W-1:0] stall_cnt,
  input logic               busy,
  input logic               ovf_evt,
  input logic               gate_ok,
  input logic               ovf_take
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count_out == CNT_W'($past(count_out) - CNT_W'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_out));
  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ovf_take));
  // R4
  decline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !gate_ok && !busy) |=> !busy && !mem_we);
  // R5
  wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy && stall_cnt == '0);
  // R6
  wr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[19:16] == 4'hF);
  // R7
  upd_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> !psw_out[IE_BIT] && stall_cnt == STALL_W'(STALL_CLKS));
  // R8
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt != '0) |-> busy && !mem_we);
endmodule

bind tmr_irq_entry tmr_irq_entry_chk #(
  .CNT_W(CNT_W), .IE_BIT(IE_BIT), .STALL_CLKS(STALL_CLKS), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .count_out(count_out),
  .mem_we(mem_we), .mem_addr(mem_addr), .psw_out(psw_out),
  .upd_valid(upd_valid), .stall_cnt(stall_cnt), .busy(busy),
  .ovf_evt(ovf_evt), .gate_ok(gate_ok), .ovf_take(ovf_take));

// File: tb/tb_tmr_irq_entry.sv
module tb_tmr_irq_entry;
  localparam logic [15:0] RC = 16'd4;
  localparam int NV = 6;
  localparam logic [15:0] T_SP  [NV] = '{16'hFE20, 16'h0002, 16'hFE00, 16'hFE00, 16'hFE00, 16'h1000};
  localparam logic [7:0]  T_PSW [NV] = '{8'h82, 8'hFF, 8'h7F, 8'h80, 8'h80, 8'h80};
  localparam logic [19:0] T_PC  [NV] = '{20'h12345, 20'hABCDE, 20'h01000, 20'h01000, 20'h01000, 20'hF0F0F};
  localparam logic [15:0] T_VEC [NV] = '{16'h0400, 16'h0001, 16'h0400, 16'h0000, 16'h0400, 16'hFFFF};
  localparam logic [15:0] T_MSK [NV] = '{16'h0000, 16'hFFEF, 16'h0000, 16'h0000, 16'h0010, 16'h0000};
  localparam bit          T_ACC [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0, tick = 0;
  logic [7:0] psw_in = 0; logic [15:0] sp_in = 0; logic [19:0] pc_in = 0;
  logic [15:0] vec_in = 0, mask_in = 0;
  logic [15:0] count_out; logic mem_we; logic [19:0] mem_addr; logic [7:0] mem_wdata;
  logic [15:0] sp_out; logic [7:0] psw_out; logic [19:0] pc_out;
  logic upd_valid; logic [3:0] stall_cnt; logic busy;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  tmr_irq_entry #(.RESET_COUNT(RC)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .psw_in(psw_in), .sp_in(sp_in),
    .pc_in(pc_in), .vec_in(vec_in), .mask_in(mask_in), .count_out(count_out),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sp_out(sp_out), .psw_out(psw_out), .pc_out(pc_out),
    .upd_valid(upd_valid), .stall_cnt(stall_cnt), .busy(busy));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    tick = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_zero();
    while (count_out !== 16'h0) @(negedge clk);
  endtask

  // from the sample where count is zero and tick is high, check a whole entry
  task automatic check_entry(logic [15:0] sp, logic [7:0] psw, logic [19:0] pc,
                             logic [15:0] vec, bit acc);
    logic [15:0] s1, s2, s3, s4;
    s1 = sp - 16'd1; s2 = sp - 16'd2; s3 = sp - 16'd3; s4 = sp - 16'd4;
    @(negedge clk);
    chk("R2 wrap", count_out, 16'hFFFF);
    if (!acc) begin
      for (int k = 0; k < 14; k++) begin
        chk("R4 no write", mem_we, 0);
        chk("R4 no busy", busy, 0);
        chk("R4 sp kept", sp_out, 16'h0);
        chk("R4 pc kept", pc_out, 20'h0);
        @(negedge clk);
      end
      chk("R4 count runs", count_out, 16'hFFFF - 16'd14);
      return;
    end
    chk("R8 busy", busy, 1);
    chk("R5 we", mem_we, 1);
    chk("R5 addr", mem_addr, {4'hF, s1});
    chk("R5 psw", mem_wdata, psw);
    @(negedge clk);
    chk("R6 addr0", mem_addr, {4'hF, s4});
    chk("R6 pc0", mem_wdata, pc[7:0]);
    @(negedge clk);
    chk("R6 addr1", mem_addr, {4'hF, s3});
    chk("R6 pc1", mem_wdata, pc[15:8]);
    @(negedge clk);
    chk("R6 addr2", mem_addr, {4'hF, s2});
    chk("R6 pc2", mem_wdata, {4'h0, pc[19:16]});
    @(negedge clk);
    chk("R7 upd", upd_valid, 1);
    chk("R7 we off", mem_we, 0);
    chk("R7 sp", sp_out, s4);
    chk("R7 psw", psw_out, psw & 8'h7F);
    chk("R7 pc", pc_out, {4'h0, vec});
    chk("R8 stall9", stall_cnt, 9);
    chk("R9 count", count_out, 16'hFFFB);
    for (int k = 8; k >= 1; k--) begin
      @(negedge clk);
      chk("R8 stall", stall_cnt, k);
      chk("R8 busy hold", busy, 1);
      chk("R7 pulse", upd_valid, 0);
    end
    @(negedge clk);
    chk("R8 busy end", busy, 0);
    chk("R8 stall0", stall_cnt, 0);
    chk("R9 count end", count_out, 16'hFFF2);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count_out, RC);
    chk("R1 busy", busy, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 upd", upd_valid, 0);
    chk("R1 stall", stall_cnt, 0);
    chk("R1 outs", {sp_out, psw_out}, 0);
    chk("R1 pc", pc_out, 0);
    repeat (3) @(negedge clk);
    chk("R2 hold", count_out, RC);
    tick = 1;
    @(negedge clk);
    chk("R2 step", count_out, RC - 16'd1);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      sp_in = T_SP[i]; psw_in = T_PSW[i]; pc_in = T_PC[i];
      vec_in = T_VEC[i]; mask_in = T_MSK[i];
      tick = 1;
      wait_zero();
      check_entry(T_SP[i], T_PSW[i], T_PC[i], T_VEC[i], T_ACC[i]);
    end

    // R3: declined first wrap, accepted second wrap 65536 ticks later
    do_reset();
    sp_in = 16'hE000; psw_in = 8'h80; pc_in = 20'h5A5A5; vec_in = 16'h0200;
    mask_in = 16'h0010;
    tick = 1;
    wait_zero();
    check_entry(16'hE000, 8'h80, 20'h5A5A5, 16'h0200, 1'b0);
    mask_in = 16'h0000;
    wait_zero();
    check_entry(16'hE000, 8'h80, 20'h5A5A5, 16'h0200, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule